// File: doc/BRIEF.md
# Dual-Mode Synchronous Serial Slave Port

This block is a serial slave port that gives a host access to a bank of byte-wide registers. It works in either of two pin arrangements. In the 3-wire arrangement the host sends on the data pin and the port answers on a separate output pin. In the 2-wire arrangement one data pin carries both directions, and the port turns it around itself. A strap input chooses where the serial clock comes from. The host can supply it, or the port can make it by dividing the system clock.

Every transfer opens with an 8-bit header sent most significant bit first. The header holds a direction bit, a byte count and a start address. Data bytes then follow, also most significant bit first, at consecutive addresses. The port turns these into single-cycle write strobes or read strobes on a plain register bus. Its serial inputs are re-timed into the system clock domain. An active-low select frames each transfer. A separate active-low port reset clears only the serial logic and never touches the register bank.

Top module: `ssp_port`

## Requirements
- R1: Header layout (bit 7 sent first): bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold the byte count minus one, and bits 4:0 hold the start address. Each write byte gives exactly one `reg_we` pulse carrying that byte, and the address starts at the header address and rises by one per byte, wrapping modulo 32.
- R2: The port samples data-in bits on rising edges of the serial clock. The serial clock idles low.
- R3: Read data is sent most significant bit first. It changes only after falling serial clock edges. Each byte is fetched with a `reg_re` pulse at consecutive addresses starting at the header address, and `reg_rdata` must be valid from the cycle after that pulse.
- R4: In 3-wire mode (`two_wire_mode`=0), read data appears on `sdo_out`. `sdo_oe` is high while the port is selected, and `sdio_oe` stays low.
- R5: In 2-wire mode, `sdio_oe` stays low during the header and for the whole of a write transfer. During a read it rises only after the eighth header bit, and read data then appears on `sdio_out`. `sdo_oe` stays low. The two enables are never both high.
- R6: Within 4 system clocks of `cs_n` going high, both `sdo_oe` and `sdio_oe` are low.
- R7: Raising `cs_n` in the middle of a byte abandons the transfer. The partial byte is never written, and the next transfer is decoded from a fresh header.
- R8: While `port_rst_n` is low, the serial logic returns to waiting for a header, issues no bus access and drives no data pin. Register contents are unchanged.
- R9: With `self_clk_mode`=1, `sclk_out` toggles every HALF_DIV system clocks and `sclk_oe` is high. The clock runs only while the port is selected and bytes remain, and it rests low afterwards. With `self_clk_mode`=0, `sclk_oe` is low.
- R10: `reg_we` and `reg_re` are never high together. Serial clock edges after the last counted byte cause no bus access.
- R11: Synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| self_clk_mode | input | 1 | 1: port generates serial clock; 0: host supplies it |
| two_wire_mode | input | 1 | 1: shared data pin; 0: separate output pin |
| cs_n | input | 1 | Active-low select framing a transfer |
| port_rst_n | input | 1 | Active-low reset of the serial logic only |
| sclk_in | input | 1 | Serial clock from host |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for generated clock |
| sdio_in | input | 1 | Data pin, input side |
| sdio_out | output | 1 | Data pin, output side (2-wire reads) |
| sdio_oe | output | 1 | Drive enable for data pin |
| sdo_out | output | 1 | Dedicated read data output |
| sdo_oe | output | 1 | Drive enable for dedicated output |
| reg_addr | output | 5 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_re` |

## Verification
The embedded properties check on every cycle that:
- the bus strobes stay exclusive;
- the two drive enables are never on together;
- the enables drop after deselect;
- the bit counter moves only on a rising serial edge;
- the output bit moves only after a falling edge;
- the port reset parks the sequencer;
- the generated clock rests low when idle.

Only the bench scenarios can show the rest. These are the header decode and address stepping, the data values read back in each of the four mode combinations, when the 2-wire pin turns around, that a partial byte is dropped on abort, and that registers keep their values across a port reset.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_DONE = 2'd3
  } ssp_state_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= RST_VAL;
    else     st[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= RST_VAL;
      else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ssp_clk.sv
module ssp_clk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic prst,
  input  logic self_mode,
  input  logic run,
  input  logic ext_lvl,
  output logic gen,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic grise, gfall, ext_q, erise, efall;

  // Internal divider: free-runs only while a transfer is open
  always_ff @(posedge clk) begin
    if (rst || prst || !self_mode || !run) begin
      cnt   <= '0;
      gen   <= 1'b0;
      grise <= 1'b0;
      gfall <= 1'b0;
    end else begin
      grise <= 1'b0;
      gfall <= 1'b0;
      if (cnt == CW'(HALF_DIV - 1)) begin
        cnt   <= '0;
        gen   <= ~gen;
        grise <= ~gen;
        gfall <= gen;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Edge detection of the re-timed host clock
  always_ff @(posedge clk) begin
    if (rst || prst) begin
      ext_q <= 1'b0;
      erise <= 1'b0;
      efall <= 1'b0;
    end else begin
      ext_q <= ext_lvl;
      erise <= ext_lvl & ~ext_q;
      efall <= ~ext_lvl & ext_q;
    end
  end

  assign rise = self_mode ? grise : erise;
  assign fall = self_mode ? gfall : efall;

  // R9: generated clock rests low whenever the transfer is not running
  assert_clk_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !gen) else $error("generated clock active while idle");

  // R2: a single pulse never marks both edges
  assert_edge_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall)) else $error("rise and fall together");
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  localparam int ADDR_W = DATA_W - 1 - CNT_W,
  localparam int BC_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prst,
  input  logic              sel,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              out_bit,
  output logic              rd_phase,
  output logic              xfer_open
);
  ssp_state_t        state;
  logic [BC_W-1:0]   bit_cnt;
  logic [DATA_W-1:0] sr, sr_next, tx;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] cur_addr;
  logic              re_d;
  logic              last_bit;

  assign sr_next   = {sr[DATA_W-2:0], din};
  assign last_bit  = (bit_cnt == BC_W'(DATA_W - 1));
  assign xfer_open = (state != ST_DONE);

  always_ff @(posedge clk) begin
    if (rst || prst || !sel) begin
      state     <= ST_HDR;
      bit_cnt   <= '0;
      sr        <= '0;
      tx        <= '0;
      remain    <= '0;
      cur_addr  <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      re_d      <= 1'b0;
      out_bit   <= 1'b0;
      rd_phase  <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      re_d   <= reg_re;
      if (re_d) begin
        tx <= reg_rdata;
      end else if (fall && state == ST_RD) begin
        out_bit <= tx[DATA_W-1];
        tx      <= {tx[DATA_W-2:0], 1'b0};
      end
      if (rise) begin
        unique case (state)
          ST_HDR: begin
            sr      <= sr_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              remain   <= sr_next[DATA_W-2 -: CNT_W];
              cur_addr <= sr_next[ADDR_W-1:0];
              if (sr_next[DATA_W-1]) begin
                state    <= ST_RD;
                reg_re   <= 1'b1;
                reg_addr <= sr_next[ADDR_W-1:0];
                rd_phase <= 1'b1;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            sr      <= sr_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              reg_we    <= 1'b1;
              reg_addr  <= cur_addr;
              reg_wdata <= sr_next;
              cur_addr  <= cur_addr + 1'b1;
              if (remain == '0) state <= ST_DONE;
              else              remain <= remain - 1'b1;
            end
          end
          ST_RD: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              if (remain == '0) begin
                state <= ST_DONE;
              end else begin
                remain   <= remain - 1'b1;
                reg_re   <= 1'b1;
                reg_addr <= cur_addr + 1'b1;
                cur_addr <= cur_addr + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: write and read strobes are exclusive
  assert_bus_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re)) else $error("both bus strobes high");

  // R2: bits are counted only on rising serial edges
  assert_cnt_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $past(sel && !prst && !rise) |-> $stable(bit_cnt)) else $error("bit counted without rising edge");

  // R3: the read bit moves only after a falling edge
  assert_out_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $past(sel && !prst && !fall) |-> $stable(out_bit)) else $error("output moved without falling edge");

  // R8: port reset parks the sequencer and silences the bus
  assert_prst_park_R8: assert property (@(posedge clk) disable iff (rst)
    prst |=> (state == ST_HDR && !reg_we && !reg_re)) else $error("port reset did not park");
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 2,
  parameter int HALF_DIV = 4,
  parameter int SYNC_STG = 2,
  localparam int ADDR_W  = DATA_W - 1 - CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              self_clk_mode,
  input  logic              two_wire_mode,
  input  logic              cs_n,
  input  logic              port_rst_n,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [3:0] pins_s;
  logic       sel, prst, sclk_s, din_s;
  logic       gen, rise, fall;
  logic       out_bit, rd_phase, xfer_open, run;

  ssp_sync #(.W(4), .STAGES(SYNC_STG), .RST_VAL(4'b1100)) i_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, port_rst_n, sclk_in, sdio_in}),
    .q(pins_s)
  );

  assign sel    = ~pins_s[3];
  assign prst   = ~pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];
  assign run    = sel & ~prst & xfer_open;

  ssp_clk #(.HALF_DIV(HALF_DIV)) i_clk (
    .clk(clk), .rst(rst), .prst(prst), .self_mode(self_clk_mode),
    .run(run), .ext_lvl(sclk_s), .gen(gen), .rise(rise), .fall(fall)
  );

  ssp_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst(rst), .prst(prst), .sel(sel), .rise(rise), .fall(fall),
    .din(din_s), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .out_bit(out_bit),
    .rd_phase(rd_phase), .xfer_open(xfer_open)
  );

  // Registered pad controls
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe   <= 1'b0;
      sdio_oe  <= 1'b0;
      sdo_out  <= 1'b0;
      sdio_out <= 1'b0;
      sclk_oe  <= 1'b0;
    end else begin
      sdo_oe   <= sel & ~prst & ~two_wire_mode;
      sdio_oe  <= sel & ~prst & two_wire_mode & rd_phase;
      sdo_out  <= out_bit;
      sdio_out <= out_bit;
      sclk_oe  <= sel & ~prst & self_clk_mode;
    end
  end

  assign sclk_out = gen;

  // R6: deselect removes both drivers on the following cycle
  assert_cs_float_R6: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!sdo_oe && !sdio_oe)) else $error("driver on while deselected");

  // R5: the two data drivers never overlap
  assert_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(sdo_oe && sdio_oe)) else $error("both data drivers on");

  // R9: no generated clock drive in host-clocked mode
  assert_ext_noclk_R9: assert property (@(posedge clk) disable iff (rst)
    !self_clk_mode |=> !sclk_oe) else $error("clock driven in host mode");
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sm = 1'b0, tw = 1'b0;
  logic cs_n = 1'b1, port_rst_n = 1'b1, sclk_in = 1'b0, host_d = 1'b0;
  logic sclk_out, sclk_oe, sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, rdata_q;
  logic reg_we, reg_re;
  logic [7:0] mem [32];
  int we_cnt = 0;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  ssp_port i_ssp_port (
    .clk(clk), .rst(rst), .self_clk_mode(sm), .two_wire_mode(tw),
    .cs_n(cs_n), .port_rst_n(port_rst_n), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdio_in(host_d),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(rdata_q)
  );

  // Register bank model
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re) rdata_q <= mem[reg_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic bit_x(input logic d, output logic q, output logic oe);
    host_d = d;
    if (!sm) begin
      repeat (8) @(negedge clk);
      q  = tw ? sdio_out : sdo_out;
      oe = tw ? sdio_oe : sdo_oe;
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end else begin
      @(posedge sclk_out);
      @(negedge clk);
      q  = tw ? sdio_out : sdo_out;
      oe = tw ? sdio_oe : sdo_oe;
      @(negedge sclk_out);
      @(negedge clk);
    end
  endtask

  // Full transfer: header then n bytes; returns read bytes packed LSB-byte first
  task automatic xfer(input logic rd, input int n, input int addr,
                      input logic [31:0] wb, output logic [31:0] rb);
    logic [7:0] h;
    logic q, oe, oe_bad, hdr_drv, sclk_seen;
    oe_bad = 1'b0; hdr_drv = 1'b0; rb = '0;
    h = {rd, 2'(n - 1), 5'(addr)};
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (tw && sdio_oe) hdr_drv = 1'b1;
      bit_x(h[i], q, oe);
    end
    check("R5 data pin not driven during header", {31'b0, hdr_drv}, 32'd0);
    check("R9 clock drive enable per mode", {31'b0, sclk_oe}, {31'b0, sm});
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        bit_x(rd ? 1'b0 : wb[8*b + i], q, oe);
        rb[8*b + i] = q;
        if (rd && !oe) oe_bad = 1'b1;
        if (!rd && tw && sdio_oe) oe_bad = 1'b1;
      end
    end
    check(rd ? "R4/R5 read driver enabled" : "R5 no drive on write", {31'b0, oe_bad}, 32'd0);
    if (!tw) check("R4 shared pin idle in 3-wire", {31'b0, sdio_oe}, 32'd0);
    else     check("R5 dedicated pin idle in 2-wire", {31'b0, sdo_oe}, 32'd0);
    sclk_seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (sclk_out) sclk_seen = 1'b1;
    end
    check("R9 generated clock rests after last byte", {31'b0, sclk_seen}, 32'd0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 drivers off after deselect", {30'b0, sdo_oe, sdio_oe}, 32'd0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rb, wb;
    logic q, oe;
    int base_we;
    for (int i = 0; i < 32; i++) mem[i] = 8'(i ^ 8'hA5);
    repeat (4) @(negedge clk);
    check("R11 reset outputs", {22'b0, sclk_out, sclk_oe, sdio_out, sdio_oe,
          sdo_out, sdo_oe, reg_we, reg_re, 2'b0}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // Sweep: both pin layouts, both clock sources, all byte counts
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 1; n <= 4; n++) begin
          int a;
          tw = t[0]; sm = s[0];
          a = (t * 13 + s * 7 + n * 9 + 29) % 32;  // wraps at top for some cases
          wb = '0;
          for (int k = 0; k < n; k++) wb[8*k +: 8] = pat(a, k + t + 2*s);
          base_we = we_cnt;
          xfer(1'b0, n, a, wb, rb);
          check("R1 write pulses equal byte count", we_cnt - base_we, n);
          for (int k = 0; k < n; k++)
            check("R1 byte written at stepped address", {24'b0, mem[(a + k) % 32]}, {24'b0, wb[8*k +: 8]});
          base_we = we_cnt;
          xfer(1'b1, n, a, '0, rb);
          check("R10 read issues no write", we_cnt - base_we, 0);
          for (int k = 0; k < n; k++)
            check("R3 read byte MSB first", {24'b0, rb[8*k +: 8]}, {24'b0, wb[8*k +: 8]});
        end
      end
    end

    // R10: extra clocks after last counted byte do nothing
    tw = 1'b0; sm = 1'b0;
    base_we = we_cnt;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_x(logic'(8'h03 >> i), q, oe);
    for (int i = 7; i >= 0; i--) bit_x(logic'(8'h5A >> i), q, oe);
    for (int i = 0; i < 16; i++) bit_x(1'b1, q, oe);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 extra clocks ignored", we_cnt - base_we, 1);
    check("R10 counted byte stored", {24'b0, mem[3]}, 32'h5A);

    // R7: abort mid-byte
    xfer(1'b0, 2, 20, 32'h0000_7700, rb);
    base_we = we_cnt;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_x(logic'(8'h34 >> i), q, oe);  // write, 2 bytes, addr 20
    for (int i = 7; i >= 0; i--) bit_x(logic'(8'h11 >> i), q, oe);
    for (int i = 7; i >= 4; i--) bit_x(logic'(8'h22 >> i), q, oe);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R7 only complete byte written", we_cnt - base_we, 1);
    xfer(1'b1, 2, 20, '0, rb);
    check("R7 complete byte kept", {24'b0, rb[7:0]}, 32'h11);
    check("R7 partial byte dropped", {24'b0, rb[15:8]}, 32'h77);

    // R8: port reset mid-transfer
    xfer(1'b0, 1, 9, 32'h3C, rb);
    base_we = we_cnt;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) bit_x(logic'(8'h09 >> i), q, oe);
    for (int i = 0; i < 3; i++) bit_x(1'b1, q, oe);
    port_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 no driver during port reset", {30'b0, sdo_oe, sdio_oe}, 32'd0);
    port_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R8 no write after port reset", we_cnt - base_we, 0);
    xfer(1'b1, 1, 9, '0, rb);
    check("R8 register value kept", {24'b0, rb[7:0]}, 32'h3C);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule